// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one event channel of a system timer. A main counter, kept elsewhere, is fed in every clock; the channel holds a comparator word and a period word and raises a one-clock fire strobe when the counter reaches the comparator. In one-shot mode the strobe comes on the equality match. In periodic mode each match also pushes the comparator forward by the period, so the channel keeps producing evenly spaced strobes. Either mode can work on the full 64-bit counter or on its low 32 bits only.

Software programs the channel through one write-data bus and three write strobes: one for the low configuration word and one for each half of the comparator. The configuration word holds the channel enable, the periodic select, a one-time "load comparator" bit and the narrow-mode bit. Its upper half is a constant capability mask. A global enable input gates the whole channel. The block does not handle interrupt routing or address decode.

Top module: `tmr_channel`

## Requirements
- R1: After reset, cmp_o is all ones, period_o is zero, fire_o and armed_o are low, and cfg_o equals {IRQ_CAP, 32'h0000_0030}. The capability flags are bit 4 (periodic capable) and bit 5 (64-bit capable), and bits 3..0 are zero.
- R2: A configuration write changes only bits 3..0 of cfg_o: bit 0 is enable, bit 1 is periodic, bit 2 is load-comparator and bit 3 is narrow mode. Bits 63..4 keep their reset value.
- R3: In one-shot mode a comparator low or high write stores the data into that half of cmp_o. In narrow mode a high-half write leaves both cmp_o and period_o unchanged.
- R4: In periodic mode with bit 2 clear, a comparator write stores the data into the matching half of period_o and leaves cmp_o unchanged.
- R5: In periodic mode with bit 2 set, a comparator write stores the data into both cmp_o and period_o. Any comparator write, of either half, clears bit 2 one clock later.
- R6: The top bit of the period is always cleared. In 64-bit mode that is bit 31 of a high-half write. In narrow mode it is bit 31 of a low-half write.
- R7: A configuration write with bit 3 set clears the upper 32 bits of cmp_o and period_o on the same clock.
- R8: armed_o rises one clock after a configuration write that turns bit 0 on while glb_en_i is high. It rises one clock after glb_en_i goes high while bit 0 is set and cmp_o is not all ones. It falls one clock after a write clears bit 0, and one clock after glb_en_i is sampled low.
- R9: In one-shot mode fire_o is high for the one clock after the edge at which count_i equals cmp_o, comparing all 64 bits, or only the low 32 bits in narrow mode. It does not repeat while the counter moves past.
- R10: In periodic mode, at an edge where the signed count_i minus cmp_o is zero or positive, fire_o goes high for one clock and cmp_o increases by period_o.
- R11: If the counter is found several periods past the comparator, exactly one strobe is produced, and cmp_o advances by one period per clock until it is ahead of count_i.
- R12: In narrow periodic mode the difference is taken on the low 32 bits as a signed value, and the comparator advances modulo 2^32 with its upper half kept at zero.
- R13: fire_o stays low while the channel is not armed, while bit 0 is clear, or when glb_en_i is low at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global timer enable |
| wr_data_i | input | 32 | Write data for configuration and comparator |
| cfg_lo_we_i | input | 1 | Write strobe, low configuration word |
| cmp_lo_we_i | input | 1 | Write strobe, comparator low half |
| cmp_hi_we_i | input | 1 | Write strobe, comparator high half |
| cfg_o | output | 64 | Configuration and capability word |
| cmp_o | output | 64 | Current comparator |
| period_o | output | 64 | Current period |
| armed_o | output | 1 | Channel is armed |
| fire_o | output | 1 | One-clock event strobe |

## Verification
All results are registered. A register write shows on cmp_o, period_o and cfg_o one clock after the edge that samples the strobe, and so does the clearing of the load-comparator bit. armed_o follows an enable change one clock later, and fire_o is high for exactly the clock after the edge that sees the counter reach the comparator. The bench drives the counter directly, holds each value for one edge and samples every output 5 ns after that edge, before it changes any input. For catch-up it holds the counter constant for several edges and counts the strobes.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   // bit positions inside the writable low configuration bits
   localparam int unsigned CFG_EN      = 0;
   localparam int unsigned CFG_PER     = 1;
   localparam int unsigned CFG_SETV    = 2;
   localparam int unsigned CFG_NARROW  = 3;
   localparam int unsigned CFG_WR_BITS = 4;
   localparam int unsigned CFG_CAP_LSB = 4;

   // packed so that bit order equals the register layout (3..0)
   typedef struct packed {
      logic narrow;
      logic setv;
      logic per;
      logic en;
   } chan_mode_t;

endpackage

// File: rtl/tmr_chan_cfg.sv
module tmr_chan_cfg
   import tmr_chan_pkg::*;
#(
   parameter int unsigned       DATA_W       = 32,
   parameter logic [DATA_W-1:0] IRQ_CAP      = '0,
   parameter bit                PERIODIC_CAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CFG_WR_BITS-1:0] wr_bits,
   input  logic                  cfg_we,
   input  logic                  cmp_we,
   input  logic                  glb_en,
   input  logic                  cmp_ones,
   output chan_mode_t            mode,
   output logic [2*DATA_W-1:0]   cfg_word,
   output logic                  armed,
   output logic                  narrow_load
);
   localparam int unsigned PAD_W = DATA_W - CFG_WR_BITS - 2;

   chan_mode_t mode_wr;
   logic       glb_q;

   assign mode_wr.en     = wr_bits[CFG_EN];
   assign mode_wr.setv   = wr_bits[CFG_SETV];
   assign mode_wr.narrow = wr_bits[CFG_NARROW];

   generate
      if (PERIODIC_CAP) begin : g_per
         assign mode_wr.per = wr_bits[CFG_PER];
      end else begin : g_noper
         assign mode_wr.per = 1'b0;
      end
   endgenerate

   assign narrow_load = cfg_we & wr_bits[CFG_NARROW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (cfg_we) begin
         mode <= mode_wr;
      end else if (cmp_we) begin
         mode.setv <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         glb_q <= glb_en;
         if (!glb_en) begin
            armed <= 1'b0;
         end else if (cfg_we && !mode_wr.en) begin
            armed <= 1'b0;
         end else if (cfg_we && mode_wr.en && !mode.en) begin
            armed <= 1'b1;
         end else if (!glb_q && mode.en && !cmp_ones) begin
            armed <= 1'b1;
         end
      end
   end

   assign cfg_word = {IRQ_CAP, {PAD_W{1'b0}}, 1'b1, PERIODIC_CAP, mode};

   // R8
   glb_low_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> !armed);

   // R5
   setv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we && !cfg_we) |=> !mode.setv);

endmodule

// File: rtl/tmr_chan_store.sv
module tmr_chan_store #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                cmp_lo_we,
   input  logic                cmp_hi_we,
   input  logic                per,
   input  logic                setv,
   input  logic                narrow,
   input  logic                narrow_load,
   input  logic                adv_en,
   input  logic [2*DATA_W-1:0] adv_cmp,
   output logic [2*DATA_W-1:0] cmp_q,
   output logic [2*DATA_W-1:0] period_q
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0]  cmp_d, period_d;
   logic [DATA_W-1:0] lo_mask, hi_mask;
   logic              load_cmp;

   assign load_cmp = !per || setv;
   assign hi_mask  = {1'b0, {(DATA_W-1){1'b1}}};
   assign lo_mask  = narrow ? hi_mask : {DATA_W{1'b1}};

   always_comb begin
      cmp_d    = cmp_q;
      period_d = period_q;
      if (adv_en) begin
         cmp_d = adv_cmp;
      end
      if (cmp_lo_we) begin
         if (load_cmp) cmp_d[DATA_W-1:0] = wr_data;
         if (per)      period_d[DATA_W-1:0] = wr_data & lo_mask;
      end
      if (cmp_hi_we && !narrow) begin
         if (load_cmp) cmp_d[CNT_W-1:DATA_W] = wr_data;
         if (per)      period_d[CNT_W-1:DATA_W] = wr_data & hi_mask;
      end
      if (narrow_load) begin
         cmp_d[CNT_W-1:DATA_W]    = '0;
         period_d[CNT_W-1:DATA_W] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q    <= '1;
         period_q <= '0;
      end else begin
         cmp_q    <= cmp_d;
         period_q <= period_d;
      end
   end

   // R6
   period_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_q[CNT_W-1]);

   // R7
   narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> (cmp_q[CNT_W-1:DATA_W] == '0) && (period_q[CNT_W-1:DATA_W] == '0));

endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match #(
   parameter int unsigned DATA_W       = 32,
   parameter bit          PERIODIC_CAP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*DATA_W-1:0] count,
   input  logic [2*DATA_W-1:0] cmp_q,
   input  logic [2*DATA_W-1:0] period_q,
   input  logic                en,
   input  logic                per,
   input  logic                narrow,
   input  logic                armed,
   input  logic                glb_en,
   input  logic                cmp_we,
   output logic                fire,
   output logic                adv_en,
   output logic [2*DATA_W-1:0] adv_cmp
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic              live, eq_hit, hit;
   logic              reached, behind, catch_q, catch_d, fire_d;

   assign live   = armed && glb_en && en;
   assign eq_hit = narrow ? (count[DATA_W-1:0] == cmp_q[DATA_W-1:0])
                          : (count == cmp_q);

   generate
      if (PERIODIC_CAP) begin : g_per
         logic [CNT_W-1:0]  gap_w, nxt_w, lead_w;
         logic [DATA_W-1:0] gap_n, nxt_n, lead_n;

         assign gap_w  = count - cmp_q;
         assign gap_n  = count[DATA_W-1:0] - cmp_q[DATA_W-1:0];
         assign nxt_w  = cmp_q + period_q;
         assign nxt_n  = cmp_q[DATA_W-1:0] + period_q[DATA_W-1:0];
         assign lead_w = count - nxt_w;
         assign lead_n = count[DATA_W-1:0] - nxt_n;

         assign reached = narrow ? !gap_n[DATA_W-1] : !gap_w[CNT_W-1];
         assign behind  = narrow ? !lead_n[DATA_W-1] : !lead_w[CNT_W-1];
         assign adv_cmp = narrow ? {{DATA_W{1'b0}}, nxt_n} : nxt_w;
      end else begin : g_noper
         assign reached = 1'b0;
         assign behind  = 1'b0;
         assign adv_cmp = cmp_q;
      end
   endgenerate

   assign hit     = per ? reached : eq_hit;
   assign adv_en  = live && per && reached;
   assign catch_d = (!live || cmp_we) ? 1'b0 : (per && reached && behind);
   assign fire_d  = live && hit && !(per && catch_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         catch_q <= 1'b0;
         fire    <= 1'b0;
      end else begin
         catch_q <= catch_d;
         fire    <= fire_d;
      end
   end

   // R13
   fire_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(armed) && $past(glb_en));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_chan_pkg::*;
#(
   parameter int unsigned       DATA_W       = 32,
   parameter logic [DATA_W-1:0] IRQ_CAP      = DATA_W'('h0000_0A04),
   parameter bit                PERIODIC_CAP = 1'b1,
   localparam int unsigned      CNT_W        = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              glb_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              cfg_lo_we_i,
   input  logic              cmp_lo_we_i,
   input  logic              cmp_hi_we_i,
   output logic [CNT_W-1:0]  cfg_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              armed_o,
   output logic              fire_o
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("tmr_channel: DATA_W must be at least 8");
      end
   endgenerate

   chan_mode_t       mode;
   logic             armed, narrow_load, cmp_we, adv_en;
   logic [CNT_W-1:0] cmp_q, period_q, adv_cmp;

   assign cmp_we = cmp_lo_we_i | cmp_hi_we_i;

   tmr_chan_cfg #(
      .DATA_W       (DATA_W),
      .IRQ_CAP      (IRQ_CAP),
      .PERIODIC_CAP (PERIODIC_CAP)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_bits     (wr_data_i[CFG_WR_BITS-1:0]),
      .cfg_we      (cfg_lo_we_i),
      .cmp_we      (cmp_we),
      .glb_en      (glb_en_i),
      .cmp_ones    (&cmp_q),
      .mode        (mode),
      .cfg_word    (cfg_o),
      .armed       (armed),
      .narrow_load (narrow_load)
   );

   tmr_chan_store #(
      .DATA_W (DATA_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_data     (wr_data_i),
      .cmp_lo_we   (cmp_lo_we_i),
      .cmp_hi_we   (cmp_hi_we_i),
      .per         (mode.per),
      .setv        (mode.setv),
      .narrow      (mode.narrow),
      .narrow_load (narrow_load),
      .adv_en      (adv_en),
      .adv_cmp     (adv_cmp),
      .cmp_q       (cmp_q),
      .period_q    (period_q)
   );

   tmr_chan_match #(
      .DATA_W       (DATA_W),
      .PERIODIC_CAP (PERIODIC_CAP)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count_i),
      .cmp_q    (cmp_q),
      .period_q (period_q),
      .en       (mode.en),
      .per      (mode.per),
      .narrow   (mode.narrow),
      .armed    (armed),
      .glb_en   (glb_en_i),
      .cmp_we   (cmp_we),
      .fire     (fire_o),
      .adv_en   (adv_en),
      .adv_cmp  (adv_cmp)
   );

   assign cmp_o    = cmp_q;
   assign period_o = period_q;
   assign armed_o  = armed;

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] count_i = '0;
   logic        glb_en_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic        cfg_lo_we_i = 1'b0;
   logic        cmp_lo_we_i = 1'b0;
   logic        cmp_hi_we_i = 1'b0;
   logic [63:0] cfg_o, cmp_o, period_o;
   logic        armed_o, fire_o;

   int total = 0;
   int errs  = 0;

   always #10 clk = ~clk;

   tmr_channel dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .count_i     (count_i),
      .glb_en_i    (glb_en_i),
      .wr_data_i   (wr_data_i),
      .cfg_lo_we_i (cfg_lo_we_i),
      .cmp_lo_we_i (cmp_lo_we_i),
      .cmp_hi_we_i (cmp_hi_we_i),
      .cfg_o       (cfg_o),
      .cmp_o       (cmp_o),
      .period_o    (period_o),
      .armed_o     (armed_o),
      .fire_o      (fire_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #5;
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      wr_data_i = v; cfg_lo_we_i = 1'b1; step(); cfg_lo_we_i = 1'b0;
   endtask

   task automatic wr_clo(input logic [31:0] v);
      wr_data_i = v; cmp_lo_we_i = 1'b1; step(); cmp_lo_we_i = 1'b0;
   endtask

   task automatic wr_chi(input logic [31:0] v);
      wr_data_i = v; cmp_hi_we_i = 1'b1; step(); cmp_hi_we_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "cfg", cfg_o, 64'h0000_0A04_0000_0030);
      chk("R1", "cmp", cmp_o, '1);
      chk("R1", "period", period_o, '0);
      chk("R1", "fire", {63'd0, fire_o}, 64'd0);
      chk("R1", "armed", {63'd0, armed_o}, 64'd0);
   endtask

   task automatic t_cfg_ro();
      wr_cfg(32'hFFFF_FFF0);
      chk("R2", "cfg after ones write", cfg_o, 64'h0000_0A04_0000_0030);
      wr_cfg(32'h0);
   endtask

   task automatic t_oneshot();
      count_i = 64'd0; glb_en_i = 1'b0;
      wr_clo(32'd100);
      wr_chi(32'd0);
      chk("R3", "oneshot cmp", cmp_o, 64'd100);
      wr_cfg(32'h1);
      chk("R8", "no arm without global", {63'd0, armed_o}, 64'd0);
      glb_en_i = 1'b1; step();
      chk("R8", "arm on global rise", {63'd0, armed_o}, 64'd1);
      count_i = 64'd99;  step();
      chk("R9", "fire before match", {63'd0, fire_o}, 64'd0);
      count_i = 64'd100; step();
      chk("R9", "fire on match", {63'd0, fire_o}, 64'd1);
      count_i = 64'd101; step();
      chk("R9", "no refire", {63'd0, fire_o}, 64'd0);
   endtask

   task automatic t_oneshot_narrow();
      wr_chi(32'd5);
      chk("R3", "oneshot hi write", cmp_o, 64'h5_0000_0064);
      wr_cfg(32'h9);
      chk("R7", "narrow truncates cmp", cmp_o, 64'h64);
      wr_chi(32'h1234);
      chk("R3", "narrow hi write ignored", cmp_o, 64'h64);
      count_i = 64'h7_0000_0063; step();
      chk("R9", "narrow no early fire", {63'd0, fire_o}, 64'd0);
      count_i = 64'h7_0000_0064; step();
      chk("R9", "narrow low-half match", {63'd0, fire_o}, 64'd1);
      count_i = 64'd0; step();
   endtask

   task automatic t_periodic();
      int fires;
      wr_cfg(32'h0);
      chk("R8", "disarm on enable clear", {63'd0, armed_o}, 64'd0);
      count_i = 64'h64; step();
      chk("R13", "disabled no fire", {63'd0, fire_o}, 64'd0);
      count_i = 64'd0;
      wr_cfg(32'h2);
      wr_clo(32'h40);
      chk("R4", "period loaded", period_o, 64'h40);
      chk("R4", "cmp kept", cmp_o, 64'h64);
      wr_cfg(32'h6);
      wr_clo(32'd200);
      chk("R5", "setv cmp", cmp_o, 64'd200);
      chk("R5", "setv period", period_o, 64'd200);
      chk("R5", "setv cleared", {63'd0, cfg_o[2]}, 64'd0);
      wr_clo(32'd50);
      chk("R4", "cmp kept after clear", cmp_o, 64'd200);
      wr_cfg(32'h3);
      chk("R8", "arm on enable", {63'd0, armed_o}, 64'd1);
      count_i = 64'd199; step();
      chk("R10", "no early fire", {63'd0, fire_o}, 64'd0);
      count_i = 64'd200; step();
      chk("R10", "fire on reach", {63'd0, fire_o}, 64'd1);
      chk("R10", "cmp advanced", cmp_o, 64'd250);
      count_i = 64'd250; step();
      chk("R10", "second fire", {63'd0, fire_o}, 64'd1);
      chk("R10", "cmp advanced again", cmp_o, 64'd300);
      count_i = 64'd420;
      fires = 0;
      for (int i = 0; i < 4; i++) begin
         step();
         if (fire_o) fires++;
      end
      chk("R11", "single strobe on catch-up", 64'(fires), 64'd1);
      chk("R11", "cmp caught up", cmp_o, 64'd450);
      glb_en_i = 1'b0; count_i = 64'd450; step();
      chk("R13", "global low no fire", {63'd0, fire_o}, 64'd0);
      chk("R8", "global low disarms", {63'd0, armed_o}, 64'd0);
      glb_en_i = 1'b1; count_i = 64'd0; step();
      chk("R8", "rearm on global rise", {63'd0, armed_o}, 64'd1);
   endtask

   task automatic t_width();
      wr_cfg(32'h2);
      wr_chi(32'hFFFF_FFFF);
      chk("R6", "wide period msb", period_o, 64'h7FFF_FFFF_0000_0032);
      chk("R4", "cmp kept on hi", cmp_o, 64'd450);
      wr_cfg(32'hA);
      chk("R7", "period truncated", period_o, 64'h32);
      chk("R7", "cmp truncated", cmp_o, 64'd450);
      wr_clo(32'hFFFF_FFFF);
      chk("R6", "narrow period msb", period_o, 64'h7FFF_FFFF);
   endtask

   task automatic t_wrap_narrow();
      count_i = 64'h3_FFFF_FF00;
      wr_cfg(32'hE);
      wr_clo(32'hFFFF_FFF0);
      chk("R5", "narrow setv cmp", cmp_o, 64'hFFFF_FFF0);
      wr_clo(32'h20);
      chk("R4", "narrow period", period_o, 64'h20);
      wr_cfg(32'hB);
      chk("R12", "no fire before reach", {63'd0, fire_o}, 64'd0);
      count_i = 64'h3_FFFF_FFF0; step();
      chk("R12", "fire at top", {63'd0, fire_o}, 64'd1);
      chk("R12", "cmp wrapped", cmp_o, 64'h10);
      count_i = 64'h4_0000_0005; step();
      chk("R12", "no fire after wrap", {63'd0, fire_o}, 64'd0);
      count_i = 64'h4_0000_0010; step();
      chk("R12", "fire after wrap", {63'd0, fire_o}, 64'd1);
      chk("R12", "cmp next", cmp_o, 64'h30);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      step();
      t_reset();
      t_cfg_ro();
      t_oneshot();
      t_oneshot_narrow();
      t_periodic();
      t_width();
      t_wrap_narrow();
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
   end
endmodule